// File: doc/BRIEF.md
# Dual Wiper Register Manager with Write Protect

This block sits behind a two-wire serial receiver in a dual digital potentiometer. It receives one already-validated command byte and one data byte per transaction, on a single-cycle strobe that the receiver raises at the end of the frame. The block keeps two 8-bit wiper channels. Each channel has a working register and a retained register. The working register drives the wiper code. The retained register is built from flip-flops that stand in for the non-volatile cell.

The low nibble of the command picks the channel or channels. The high nibble picks one of four operations: load the working register from the data byte, program the retained register from the data byte, recall the retained value into the working register, or store the working value into the retained register.

A protect input changes what these operations do. While protect is high, a working-register load turns into a recall, and any operation that would write retained storage does nothing. Protect is active high, so a pull-up on an open pin gives the safe state.

Each retained write starts a busy window that models the programming time. Its length is the parameter `BUSY_CYCLES`; the default is 12 ms at 250 MHz. Any command that arrives while the window is open is dropped and reported on a one-cycle reject flag. A synchronous reset reloads both working registers from retained storage, and retained storage keeps its contents through the reset. The retained registers start at midscale.

Top module: `dual_wiper_mgr`

## Requirements
- R1: After the first reset both wiper codes and both retained values read 0x80, and `busy_o` and `cmd_reject_o` are 0.
- R2: Command bits [3:0] select the channels: 1 selects channel A only, 2 selects channel B only, 3 selects both. An unselected channel keeps both of its registers.
- R3: Command bits [7:4] = 1 with protect low loads the data byte into the wiper code of each selected channel and leaves the retained values unchanged.
- R4: Command bits [7:4] = 2 with protect low writes the data byte into the retained register of each selected channel, leaves the wiper codes unchanged, and raises `busy_o`.
- R5: Command bits [7:4] = 6 copies each selected retained value into its wiper code, whatever the protect level.
- R6: Command bits [7:4] = 5 with protect low copies each selected wiper code into its retained register, leaves the wiper codes unchanged, and raises `busy_o`.
- R7: With protect high, command bits [7:4] = 1 copies the retained value into the wiper code and ignores the data byte.
- R8: With protect high, command bits [7:4] = 2 or 5 change no register and do not raise `busy_o`.
- R9: An accepted retained write holds `busy_o` high for exactly `BUSY_CYCLES` cycles, counted from the cycle after the command strobe. Selecting both channels starts a single window.
- R10: A command strobe that arrives while `busy_o` is high changes no register. `cmd_reject_o` is high in the following cycle only.
- R11: A command whose high nibble is not 1, 2, 5 or 6, or whose low nibble is not 1, 2 or 3, changes no register and does not raise `busy_o`.
- R12: A reset taken after retained values have changed reloads each wiper code from its retained register, and retained values survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the wiper codes from retained storage |
| wp_i | input | 1 | Write protect, active high |
| cmd_valid_i | input | 1 | One-cycle strobe: command and data are complete |
| cmd_i | input | 8 | Command byte: [7:4] operation, [3:0] channel select |
| data_i | input | 8 | Data byte |
| wiper_a_o | output | 8 | Wiper code of channel A |
| wiper_b_o | output | 8 | Wiper code of channel B |
| nv_a_o | output | 8 | Retained value of channel A |
| nv_b_o | output | 8 | Retained value of channel B |
| busy_o | output | 1 | Retained-write busy window is open |
| cmd_reject_o | output | 1 | The previous cycle's strobe was dropped because the block was busy |

## Verification
Each register is visible at the ports, so a wrong working or retained value shows up one cycle after the strobe that produced it. A wrong protect remap shows up the same way.

A busy counter that loads the wrong value or stops at the wrong count is caught in two ways:
- Directly, by counting how many cycles `busy_o` stays high.
- Indirectly, when later commands are rejected or accepted at the wrong time.

A decode fault on any of the 256 command codes shows up as a stray change in one of the four register outputs, because the bench issues every code under both protect levels. A lost retained value appears only after the next reset, when the wiper reloads.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

    localparam int BYTE_W     = 8;
    localparam int NIB_W      = 4;
    localparam int NUM_CH     = 2;
    localparam logic [BYTE_W-1:0] NV_DEFAULT = 8'h80;

    // operation codes carried in the command high nibble
    localparam logic [NIB_W-1:0] OPC_VOL_WR = 4'h1;
    localparam logic [NIB_W-1:0] OPC_NV_WR  = 4'h2;
    localparam logic [NIB_W-1:0] OPC_STORE  = 4'h5;
    localparam logic [NIB_W-1:0] OPC_RECALL = 4'h6;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_VOL_WR,
        OP_NV_WR,
        OP_STORE,
        OP_RECALL
    } op_e;

    // per-channel action after protect remapping
    typedef struct packed {
        logic vol_ld;        // update working register
        logic vol_from_data; // 1: data byte, 0: retained value
        logic nv_ld;         // update retained register
        logic nv_from_data;  // 1: data byte, 0: working value
    } ch_act_t;

    function automatic op_e decode_op(input logic [NIB_W-1:0] nib);
        case (nib)
            OPC_VOL_WR: return OP_VOL_WR;
            OPC_NV_WR:  return OP_NV_WR;
            OPC_STORE:  return OP_STORE;
            OPC_RECALL: return OP_RECALL;
            default:    return OP_NONE;
        endcase
    endfunction

    // codes 1..3 map directly onto a channel bit mask; all else selects none
    function automatic logic [NUM_CH-1:0] decode_sel(input logic [NIB_W-1:0] nib);
        if (nib[NIB_W-1:2] == '0)
            return nib[1:0];
        return '0;
    endfunction

endpackage

// File: rtl/wiper_cmd_decode.sv
module wiper_cmd_decode
    import wiper_pkg::*;
(
    input  logic              cmd_valid_i,
    input  logic              busy_i,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] cmd_i,
    output ch_act_t           act_o [NUM_CH],
    output logic              nv_start_o,
    output logic              reject_o
);

    op_e               op;
    logic [NUM_CH-1:0] sel;
    logic              accept;
    ch_act_t           act_sel;

    always_comb begin
        op       = decode_op(cmd_i[BYTE_W-1:NIB_W]);
        sel      = decode_sel(cmd_i[NIB_W-1:0]);
        accept   = cmd_valid_i && !busy_i && (op != OP_NONE) && (sel != '0);
        reject_o = cmd_valid_i && busy_i;

        act_sel = '0;
        unique case (op)
            OP_VOL_WR: begin
                act_sel.vol_ld        = 1'b1;
                act_sel.vol_from_data = !wp_i;   // protected: becomes a recall
            end
            OP_RECALL: act_sel.vol_ld = 1'b1;
            OP_NV_WR: begin
                act_sel.nv_ld        = !wp_i;
                act_sel.nv_from_data = 1'b1;
            end
            OP_STORE:  act_sel.nv_ld = !wp_i;
            default:   act_sel = '0;
        endcase

        nv_start_o = accept && act_sel.nv_ld;
        for (int i = 0; i < NUM_CH; i++)
            act_o[i] = (accept && sel[i]) ? act_sel : '0;
    end

endmodule

// File: rtl/wiper_busy_timer.sv
module wiper_busy_timer #(
    parameter int BUSY_CYCLES = 3_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // decoder must never start a window while one is open
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start_i |-> !busy_o);

    // window keeps running until its last cycle
    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy_o && (cnt_q > CNT_W'(1))) |=> busy_o);

    // a started window is open on the next cycle
    p_busy_opens_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

endmodule

// File: rtl/wiper_channel.sv
module wiper_channel
    import wiper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ch_act_t           act_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [BYTE_W-1:0] vol_o,
    output logic [BYTE_W-1:0] nv_o
);

    logic [BYTE_W-1:0] vol_q;
    logic [BYTE_W-1:0] nv_q;

    // retained storage: factory preload, untouched by reset
    initial nv_q = NV_DEFAULT;

    always @(posedge clk) begin
        if (!rst && act_i.nv_ld)
            nv_q <= act_i.nv_from_data ? data_i : vol_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vol_q <= nv_q;
        else if (act_i.vol_ld)
            vol_q <= act_i.vol_from_data ? data_i : nv_q;
    end

    assign vol_o = vol_q;
    assign nv_o  = nv_q;

    // first cycle after reset: working register equals retained value
    always_ff @(posedge clk) begin
        if (!rst && $past(rst))
            p_restore_r12: assert (vol_q == nv_q);
    end

endmodule

// File: rtl/dual_wiper_mgr.sv
module dual_wiper_mgr
    import wiper_pkg::*;
#(
    parameter int BUSY_CYCLES = 3_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_i,
    input  logic              cmd_valid_i,
    input  logic [BYTE_W-1:0] cmd_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [BYTE_W-1:0] wiper_a_o,
    output logic [BYTE_W-1:0] wiper_b_o,
    output logic [BYTE_W-1:0] nv_a_o,
    output logic [BYTE_W-1:0] nv_b_o,
    output logic              busy_o,
    output logic              cmd_reject_o
);

    ch_act_t           act [NUM_CH];
    logic              nv_start;
    logic              reject_now;
    logic              reject_q;
    logic [BYTE_W-1:0] vol [NUM_CH];
    logic [BYTE_W-1:0] nv  [NUM_CH];

    wiper_cmd_decode u_dec (
        .cmd_valid_i (cmd_valid_i),
        .busy_i      (busy_o),
        .wp_i        (wp_i),
        .cmd_i       (cmd_i),
        .act_o       (act),
        .nv_start_o  (nv_start),
        .reject_o    (reject_now)
    );

    wiper_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst     (rst),
        .start_i (nv_start),
        .busy_o  (busy_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        wiper_channel u_ch (
            .clk    (clk),
            .rst    (rst),
            .act_i  (act[g]),
            .data_i (data_i),
            .vol_o  (vol[g]),
            .nv_o   (nv[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) reject_q <= 1'b0;
        else     reject_q <= reject_now;
    end

    assign wiper_a_o    = vol[0];
    assign wiper_b_o    = vol[1];
    assign nv_a_o       = nv[0];
    assign nv_b_o       = nv[1];
    assign cmd_reject_o = reject_q;

    p_wp_freezes_nv_r8: assert property (@(posedge clk) disable iff (rst)
        wp_i |=> ($stable(nv_a_o) && $stable(nv_b_o)));

    p_nv_change_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !($stable(nv_a_o) && $stable(nv_b_o)) |-> busy_o);

    p_busy_reject_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && busy_o) |=>
            (cmd_reject_o && $stable(wiper_a_o) && $stable(wiper_b_o)
             && $stable(nv_a_o) && $stable(nv_b_o)));

    p_reject_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid_i && busy_o) |=> !cmd_reject_o);

endmodule

// File: tb/dual_wiper_mgr_tb.sv
module dual_wiper_mgr_tb;

    localparam int N = 24;

    logic       clk = 1'b0;
    logic       rst;
    logic       wp;
    logic       valid;
    logic [7:0] cmd;
    logic [7:0] data;
    logic [7:0] wa, wb, na, nb;
    logic       busy, rej;

    int checks   = 0;
    int failures = 0;

    // expected state
    logic [7:0] mv [2];
    logic [7:0] mn [2];
    logic       m_start;

    dual_wiper_mgr #(.BUSY_CYCLES(N)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .wp_i         (wp),
        .cmd_valid_i  (valid),
        .cmd_i        (cmd),
        .data_i       (data),
        .wiper_a_o    (wa),
        .wiper_b_o    (wb),
        .nv_a_o       (na),
        .nv_b_o       (nb),
        .busy_o       (busy),
        .cmd_reject_o (rej)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, input logic [7:0] d, input logic w);
        wp = w; cmd = c; data = d; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // model of one accepted command
    task automatic predict(input logic [7:0] c, input logic [7:0] d, input logic w);
        logic [1:0] sel;
        logic [3:0] op;
        op  = c[7:4];
        sel = (c[3:0] >= 4'd1 && c[3:0] <= 4'd3) ? c[1:0] : 2'b00;
        m_start = 1'b0;
        if (!(op == 4'h1 || op == 4'h2 || op == 4'h5 || op == 4'h6)) sel = 2'b00;
        for (int i = 0; i < 2; i++) begin
            if (sel[i]) begin
                case (op)
                    4'h1: mv[i] = w ? mn[i] : d;
                    4'h6: mv[i] = mn[i];
                    4'h2: if (!w) mn[i] = d;
                    4'h5: if (!w) mn[i] = mv[i];
                    default: ;
                endcase
            end
        end
        if (sel != 2'b00 && !w && (op == 4'h2 || op == 4'h5)) m_start = 1'b1;
    endtask

    function automatic string tag_of(input logic [7:0] c, input logic w);
        logic [3:0] op;
        op = c[7:4];
        if (!(op == 4'h1 || op == 4'h2 || op == 4'h5 || op == 4'h6)
            || c[3:0] == 4'd0 || c[3:0] > 4'd3) return "R11";
        if (w && op == 4'h1) return "R7";
        if (w && (op == 4'h2 || op == 4'h5)) return "R8";
        case (op)
            4'h1: return "R3";
            4'h2: return "R4";
            4'h6: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk_state(input string tag);
        chk(tag, {wa, wb, na, nb}, {mv[0], mv[1], mn[0], mn[1]});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int cnt;
        logic [7:0] d;
        rst = 1'b1; wp = 1'b1; valid = 1'b0; cmd = '0; data = '0;
        mv[0] = 8'h80; mv[1] = 8'h80; mn[0] = 8'h80; mn[1] = 8'h80;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk_state("R1 state");
        chk("R1 busy/reject", {busy, rej}, 2'b00);

        // R2: channel selection
        send(8'h11, 8'h21, 1'b0); predict(8'h11, 8'h21, 1'b0);
        chk_state("R2 select A");
        send(8'h12, 8'h42, 1'b0); predict(8'h12, 8'h42, 1'b0);
        chk_state("R2 select B");
        send(8'h13, 8'h63, 1'b0); predict(8'h13, 8'h63, 1'b0);
        chk_state("R2 select both");

        // sweep: every command code under both protect levels
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 256; c++) begin
                wait_idle();
                d = 8'(c * 37 + w * 91 + 11);
                predict(8'(c), d, w[0]);
                send(8'(c), d, w[0]);
                chk_state(tag_of(8'(c), w[0]));
                chk({tag_of(8'(c), w[0]), " busy"}, {31'd0, busy}, {31'd0, m_start});
            end
        end

        // R9: single busy window for a both-channel retained write
        wait_idle();
        predict(8'h23, 8'h5A, 1'b0);
        send(8'h23, 8'h5A, 1'b0);
        chk_state("R9 both written");
        cnt = 0;
        while (busy && cnt < 10 * N) begin
            cnt++;
            @(negedge clk);
        end
        chk("R9 busy length", cnt, N);

        // R10: command during busy is dropped and flagged for one cycle
        predict(8'h53, 8'h00, 1'b0);
        send(8'h53, 8'h00, 1'b0);
        chk("R10 busy open", {31'd0, busy}, 32'd1);
        send(8'h11, 8'h99, 1'b0);
        chk_state("R10 no change");
        chk("R10 reject flag", {31'd0, rej}, 32'd1);
        @(negedge clk);
        chk("R10 reject one cycle", {31'd0, rej}, 32'd0);
        wait_idle();

        // R12: reset reloads wipers from retained storage
        predict(8'h21, 8'h3C, 1'b0);
        send(8'h21, 8'h3C, 1'b0);
        wait_idle();
        predict(8'h13, 8'hC3, 1'b0);
        send(8'h13, 8'hC3, 1'b0);
        chk_state("R12 before reset");
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        mv[0] = mn[0]; mv[1] = mn[1];
        chk_state("R12 after reset");
        chk("R12 wiper A", {24'd0, wa}, 32'h3C);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule